// File: doc/BRIEF.md
# Dual-Channel IDE Programmed-I/O Address Decoder

This block sits between a host I/O port and the register slots of a two-channel IDE controller. Each request address is compared against five programmable windows. Two windows belong to each channel: a command block and a control block. The fifth window holds the bus-master registers. For every access the decoder reports the block type, the channel and the offset inside the window. It then forwards the access as a transfer to one of four drive slots, or to the bus-master registers, and returns a response with read data or an error flag.

Each channel keeps its own drive-select bit. A byte write to a channel's drive/head select offset updates that bit. Drive slot numbers combine the channel with that bit, so slots 0 and 1 belong to the primary channel and slots 2 and 3 to the secondary channel. A 32-bit access to the data port is split into two 16-bit transfers on consecutive cycles, low half first. Accesses are silenced when I/O space is disabled, and reads from unpopulated slots return zero.

Top module: `ide_pio_dec`

## Requirements
- R1: A window hits when base <= addr < base + size. The sizes are 8 for a command block, 4 for a control block and 16 for bus-master. The transfer offset is addr - base. Block codes are 0 for command, 1 for control and 2 for bus-master. Channel 0 is primary and channel 1 is secondary.
- R2: When windows overlap, the first match in this order wins: primary command, primary control, secondary command, secondary control, bus-master. After reset every base is 0.
- R3: A bus-master hit with offset below 8 belongs to channel 0. Any other bus-master hit belongs to channel 1.
- R4: Base index 0..4 (in the order of R2) is loaded from a configuration write only when the written value is nonzero. A zero write keeps the old base.
- R5: While io_en_i is low, a legal access that hits a window produces no transfer, returns zero data with no error, and leaves the drive-select bits unchanged.
- R6: A legal, enabled byte write to command offset 6 sets that channel's drive bit to wdata bit 4. The bits are visible on dev_sel_o, with bit 0 for primary and bit 1 for secondary.
- R7: The slot is 2*channel + drive bit. A select write is routed using the newly written bit.
- R8: A command or control access aimed at a slot whose slot_present_i bit is 0 makes no transfer. A read of such a slot returns zero data.
- R9: Offset 0 of a command or control block is the data port. A 16-bit access there is one transfer. A 32-bit access there is two 16-bit transfers on consecutive cycles: first the low half with beat 0, then the high half with beat 1. A 32-bit read returns {high, low}. req_ready_o is low for the one cycle in which the first half is presented.
- R10: Size codes are 0 for byte, 1 for 16-bit, 2 for 32-bit and 3 for illegal. The data port takes only sizes 1 and 2. Other command and control offsets take only size 0. Bus-master takes sizes 0 to 2. A violation returns an error response with zero data and makes no transfer.
- R11: An address that hits no window returns an error response with zero data, whether or not I/O is enabled. The error flag lasts exactly one cycle.
- R12: After reset the drive bits are 0, req_ready_o is high, and no transfer or response is pending.
- R13: A transfer appears in the cycle after the request is accepted. The response is valid for one cycle, in the cycle after the last transfer of the access, or in the cycle after acceptance when no transfer is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Base register write strobe |
| cfg_sel_i | input | 3 | Window index 0..4 |
| cfg_data_i | input | 16 | New base value |
| io_en_i | input | 1 | I/O space enable |
| slot_present_i | input | 4 | Populated drive slots |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Request may be accepted |
| req_write_i | input | 1 | 1 = write |
| req_addr_i | input | 16 | I/O address |
| req_size_i | input | 2 | Access size code |
| req_wdata_i | input | 32 | Write data |
| xfer_valid_o | output | 1 | Transfer to a slot or bus-master registers |
| xfer_write_o | output | 1 | Transfer is a write |
| xfer_blk_o | output | 2 | Block type |
| xfer_chan_o | output | 1 | Channel |
| xfer_slot_o | output | 2 | Drive slot |
| xfer_off_o | output | 4 | Offset in window |
| xfer_size_o | output | 2 | Transfer size code |
| xfer_beat_o | output | 1 | 1 on the high half of a split access |
| xfer_wdata_o | output | 32 | Transfer write data |
| dev_rdata_i | input | 32 | Read data for the current transfer |
| rsp_valid_o | output | 1 | Response valid |
| rsp_err_o | output | 1 | Error pulse |
| rsp_rdata_o | output | 32 | Read data |
| dev_sel_o | output | 2 | Drive-select bits per channel |

## Verification
The bench presents a request ahead of a rising edge and clears it at the next falling edge. The first transfer is checked at that falling edge, one edge after acceptance. For a split data-port access, the high half is checked one falling edge later. The response is checked at the falling edge after the last transfer, or one edge after acceptance when nothing is forwarded. One more falling edge is used to confirm that the response and error flag have dropped. The bench also checks the drive-select bits after every access, and it checks every sampled value against its own model of bases, drive bits and slot population.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  typedef enum logic [1:0] {BLK_CMD = 2'd0, BLK_CTRL = 2'd1, BLK_BM = 2'd2} blk_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_BAD = 2'd3} size_e;
  localparam int NWIN = 5;
  localparam int WIN_BM = 4;
endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int AW   = 16,
  parameter int OW   = 4,
  parameter int SIZE = 8,
  parameter int IDX  = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_data_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [OW-1:0] off_o
);
  logic [AW-1:0] base_q;
  logic [AW-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (cfg_we_i && cfg_sel_i == 3'(IDX) && cfg_data_i != '0) base_q <= cfg_data_i;
  end

  assign diff  = addr_i - base_q;
  assign hit_o = (addr_i >= base_q) && (diff < AW'(SIZE));
  assign off_o = diff[OW-1:0];
endmodule

// File: rtl/ide_drv_sel.sv
module ide_drv_sel (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic       chan_i,
  input  logic       val_i,
  output logic [1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_o <= '0;
    else if (set_i) sel_o[chan_i] <= val_i;
  end
endmodule

// File: rtl/ide_pio_dec.sv
module ide_pio_dec
  import ide_dec_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CMD_SIZE  = 8,
  parameter int CTRL_SIZE = 4,
  parameter int BM_SIZE   = 16,
  parameter int BM_SPLIT  = 8,
  parameter int DATA_OFF  = 0,
  parameter int SEL_OFF   = 6,
  parameter int SEL_BIT   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_data_i,
  input  logic          io_en_i,
  input  logic [3:0]    slot_present_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic [31:0]   req_wdata_i,
  output logic          xfer_valid_o,
  output logic          xfer_write_o,
  output logic [1:0]    xfer_blk_o,
  output logic          xfer_chan_o,
  output logic [1:0]    xfer_slot_o,
  output logic [3:0]    xfer_off_o,
  output logic [1:0]    xfer_size_o,
  output logic          xfer_beat_o,
  output logic [31:0]   xfer_wdata_o,
  input  logic [31:0]   dev_rdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [31:0]   rsp_rdata_o,
  output logic [1:0]    dev_sel_o
);
  localparam int MAXW = (BM_SIZE > CMD_SIZE) ? ((BM_SIZE > CTRL_SIZE) ? BM_SIZE : CTRL_SIZE)
                                             : ((CMD_SIZE > CTRL_SIZE) ? CMD_SIZE : CTRL_SIZE);
  localparam int OW = (MAXW > 1) ? $clog2(MAXW) : 1;

  logic [NWIN-1:0] hit_w;
  logic [OW-1:0]   off_w [NWIN];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int SZ = (g == WIN_BM) ? BM_SIZE : ((g % 2) == 1 ? CTRL_SIZE : CMD_SIZE);
    ide_win_match #(.AW(AW), .OW(OW), .SIZE(SZ), .IDX(g)) u_win (
      .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_data_i,
      .addr_i(req_addr_i), .hit_o(hit_w[g]), .off_o(off_w[g])
    );
  end

  // first match in window order wins
  logic          any_hit;
  logic [2:0]    win;
  logic [OW-1:0] woff;
  always_comb begin
    any_hit = 1'b0;
    win     = '0;
    woff    = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_w[i]) begin
        any_hit = 1'b1;
        win     = 3'(i);
        woff    = off_w[i];
      end
    end
  end

  blk_e  d_blk;
  size_e d_size;
  logic  d_chan, is_data, legal, d_err, do_sel, cur_bit, d_fwd, d_split;
  logic [1:0] d_slot;
  logic [1:0] sel_bits;

  always_comb begin
    d_size  = size_e'(req_size_i);
    d_blk   = (win == 3'(WIN_BM)) ? BLK_BM : (win[0] ? BLK_CTRL : BLK_CMD);
    d_chan  = (win == 3'(WIN_BM)) ? (woff >= OW'(BM_SPLIT)) : win[1];
    is_data = (d_blk != BLK_BM) && (woff == OW'(DATA_OFF));
    legal   = (d_size != SZ_BAD) &&
              ((d_blk == BLK_BM) ||
               (is_data ? (d_size == SZ_HALF || d_size == SZ_WORD) : (d_size == SZ_BYTE)));
    d_err   = !any_hit || !legal;
    do_sel  = !d_err && io_en_i && req_write_i && (d_blk == BLK_CMD) && (woff == OW'(SEL_OFF));
    cur_bit = do_sel ? req_wdata_i[SEL_BIT] : sel_bits[d_chan];
    d_slot  = {d_chan, cur_bit};
    d_fwd   = !d_err && io_en_i && ((d_blk == BLK_BM) || slot_present_i[d_slot]);
    d_split = d_fwd && is_data && (d_size == SZ_WORD);
  end

  logic acc;
  assign acc = req_valid_i && req_ready_o;

  ide_drv_sel u_sel (
    .clk_i, .rst_ni, .set_i(acc && do_sel), .chan_i(d_chan), .val_i(req_wdata_i[SEL_BIT]),
    .sel_o(sel_bits)
  );
  assign dev_sel_o = sel_bits;

  logic          x_act, x_fwd, x_err, x_split, x_hi, x_write, x_chan;
  blk_e          x_blk;
  size_e         x_size;
  logic [1:0]    x_slot;
  logic [OW-1:0] x_off;
  logic [31:0]   x_wdata;
  logic [15:0]   lo_q;
  logic          rsp_valid_q, rsp_err_q;
  logic [31:0]   rsp_rdata_q;

  assign req_ready_o = !(x_act && x_split);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_act <= 1'b0; x_fwd <= 1'b0; x_err <= 1'b0; x_split <= 1'b0; x_hi <= 1'b0;
      x_write <= 1'b0; x_chan <= 1'b0; x_blk <= BLK_CMD; x_size <= SZ_BYTE;
      x_slot <= '0; x_off <= '0; x_wdata <= '0; lo_q <= '0;
      rsp_valid_q <= 1'b0; rsp_err_q <= 1'b0; rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      if (x_act && x_split) begin
        lo_q    <= dev_rdata_i[15:0];
        x_split <= 1'b0;
        x_hi    <= 1'b1;
      end else begin
        if (x_act) begin
          rsp_valid_q <= 1'b1;
          rsp_err_q   <= x_err;
          rsp_rdata_q <= (x_fwd && !x_write) ? (x_hi ? {dev_rdata_i[15:0], lo_q} : dev_rdata_i) : '0;
        end
        x_act <= acc;
        if (acc) begin
          x_fwd   <= d_fwd;
          x_err   <= d_err;
          x_split <= d_split;
          x_hi    <= 1'b0;
          x_write <= req_write_i;
          x_chan  <= d_chan;
          x_blk   <= d_blk;
          x_size  <= d_size;
          x_slot  <= d_slot;
          x_off   <= woff;
          x_wdata <= req_wdata_i;
        end
      end
    end
  end

  assign xfer_valid_o = x_act && x_fwd;
  assign xfer_write_o = x_write;
  assign xfer_blk_o   = x_blk;
  assign xfer_chan_o  = x_chan;
  assign xfer_slot_o  = x_slot;
  assign xfer_off_o   = 4'(x_off);
  assign xfer_size_o  = (x_split || x_hi) ? SZ_HALF : x_size;
  assign xfer_beat_o  = x_hi;
  assign xfer_wdata_o = x_split ? {16'h0, x_wdata[15:0]} : (x_hi ? {16'h0, x_wdata[31:16]} : x_wdata);
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_err_o    = rsp_err_q;
  assign rsp_rdata_o  = rsp_rdata_q;
endmodule

// File: rtl/ide_pio_dec_chk.sv
module ide_pio_dec_chk #(
  parameter int BM_SPLIT = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_write_i,
  input logic        io_en_i,
  input logic        req_ready_o,
  input logic        xfer_valid_o,
  input logic [1:0]  xfer_blk_o,
  input logic        xfer_chan_o,
  input logic [1:0]  xfer_slot_o,
  input logic [3:0]  xfer_off_o,
  input logic [1:0]  xfer_size_o,
  input logic        rsp_valid_o,
  input logic        rsp_err_o,
  input logic [31:0] rsp_rdata_o,
  input logic [1:0]  dev_sel_o
);
  a_r3_bm_chan_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && xfer_blk_o == 2'd2) |-> (xfer_chan_o == (xfer_off_o >= 4'(BM_SPLIT))));

  a_r6_sel_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dev_sel_o) |-> $past(req_valid_i && req_ready_o && req_write_i && io_en_i));

  a_r7_slot_matches_chan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && xfer_blk_o != 2'd2) |-> (xfer_slot_o[1] == xfer_chan_o));

  a_r9_first_half_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> (xfer_valid_o && xfer_size_o == 2'd1));

  a_r9_second_half_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> (req_ready_o && xfer_valid_o && xfer_size_o == 2'd1));

  a_r10_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_valid_o && rsp_rdata_o == 32'h0));

  a_r13_rsp_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && req_ready_o) |=> rsp_valid_o);
endmodule

bind ide_pio_dec ide_pio_dec_chk #(.BM_SPLIT(BM_SPLIT)) u_chk (.*);

// File: tb/ide_pio_dec_test.sv
module ide_pio_dec_test;
  localparam int CLK_PERIOD = 10;
  localparam int SZ_CMD = 8, SZ_CTRL = 4, SZ_BM = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        cfg_we = 0; logic [2:0] cfg_sel = 0; logic [15:0] cfg_data = 0;
  logic        io_en = 1;  logic [3:0] slot_present = 4'hF;
  logic        req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0; logic [1:0] req_size = 0; logic [31:0] req_wdata = 0;
  logic        req_ready, xfer_valid, xfer_write, xfer_chan, xfer_beat;
  logic [1:0]  xfer_blk, xfer_slot, xfer_size, dev_sel;
  logic [3:0]  xfer_off;
  logic [31:0] xfer_wdata, dev_rdata, rsp_rdata;
  logic        rsp_valid, rsp_err;

  function automatic logic [31:0] dev_val(logic [1:0] slot, logic beat, logic [3:0] off);
    return {8'hA5, 2'b00, slot, 3'b000, beat, off, 8'h3C, 4'h9, off};
  endfunction
  always_comb dev_rdata = dev_val(xfer_slot, xfer_beat, xfer_off);

  ide_pio_dec uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .io_en_i(io_en), .slot_present_i(slot_present), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .xfer_valid_o(xfer_valid), .xfer_write_o(xfer_write), .xfer_blk_o(xfer_blk), .xfer_chan_o(xfer_chan),
    .xfer_slot_o(xfer_slot), .xfer_off_o(xfer_off), .xfer_size_o(xfer_size), .xfer_beat_o(xfer_beat),
    .xfer_wdata_o(xfer_wdata), .dev_rdata_i(dev_rdata), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .rsp_rdata_o(rsp_rdata), .dev_sel_o(dev_sel)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_base [5];
  logic [1:0]  m_sel;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic int win_size(int w);
    return (w == 4) ? SZ_BM : ((w % 2) == 1 ? SZ_CTRL : SZ_CMD);
  endfunction

  function automatic int win_of(logic [15:0] a);
    for (int i = 0; i < 5; i++)
      if (a >= m_base[i] && (a - m_base[i]) < 16'(win_size(i))) return i;
    return -1;
  endfunction

  task automatic cfg(input logic [2:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_data = val;
    @(negedge clk);
    cfg_we = 0;
    if (val != 0) m_base[sel] = val;  // R4
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [1:0] sz, input logic [31:0] wd);
    int w; logic [3:0] off; logic [1:0] blk, slot; bit ch, isd, legal, err, dsel, bitv, fwd, split;
    logic [31:0] erd;
    w = win_of(a);
    off = 0; blk = 0; ch = 0; isd = 0; legal = 0;
    if (w >= 0) begin
      off = 4'(a - m_base[w]);
      blk = (w == 4) ? 2'd2 : 2'(w % 2);
      ch  = (w == 4) ? (off >= 4'd8) : (w / 2 == 1);
      isd = (blk != 2) && (off == 0);
      legal = (sz != 3) && ((blk == 2) || (isd ? (sz == 1 || sz == 2) : (sz == 0)));
    end
    err   = (w < 0) || !legal;
    dsel  = !err && io_en && wr && blk == 0 && off == 6;
    bitv  = dsel ? wd[4] : m_sel[ch];
    slot  = {ch, bitv};
    fwd   = !err && io_en && (blk == 2 || slot_present[slot]);
    split = fwd && isd && sz == 2;
    erd   = (!fwd || wr) ? 32'h0 :
            (split ? {dev_val(slot, 1, off)[15:0], dev_val(slot, 0, off)[15:0]} : dev_val(slot, 0, off));
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (dsel) m_sel[ch] = bitv;
    chk("R13/R5/R8 transfer present", 32'(xfer_valid), 32'(fwd));
    chk("R9 ready during first half", 32'(req_ready), 32'(!split));
    if (fwd) begin
      chk("R1/R2 block", 32'(xfer_blk), 32'(blk));
      chk("R1 offset", 32'(xfer_off), 32'(off));
      chk("R3 channel", 32'(xfer_chan), 32'(ch));
      if (blk != 2) chk("R7 slot", 32'(xfer_slot), 32'(slot));
      chk("R9 size beat0", 32'(xfer_size), split ? 32'd1 : 32'(sz));
      chk("R9 beat0 data", xfer_wdata, split ? {16'h0, wd[15:0]} : wd);
      chk("R9 beat0 flag", 32'(xfer_beat), 32'd0);
      chk("R1 write flag", 32'(xfer_write), 32'(wr));
    end
    if (split) begin
      @(negedge clk);
      chk("R9 second half valid", 32'(xfer_valid), 32'd1);
      chk("R9 second half flag", 32'(xfer_beat), 32'd1);
      chk("R9 second half data", xfer_wdata, {16'h0, wd[31:16]});
      chk("R9 ready after split", 32'(req_ready), 32'd1);
    end
    @(negedge clk);
    chk("R13 response valid", 32'(rsp_valid), 32'd1);
    chk("R10/R11 error flag", 32'(rsp_err), 32'(err));
    chk("R8/R9 read data", rsp_rdata, erd);
    chk("R13 no transfer after", 32'(xfer_valid), 32'd0);
    @(negedge clk);
    chk("R11 one-cycle response", 32'(rsp_valid), 32'd0);
    chk("R6 drive bits", 32'(dev_sel), 32'(m_sel));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 5; i++) m_base[i] = 16'h0;
    m_sel = 2'b00;
    #(3 * CLK_PERIOD + 2);
    chk("R12 ready at reset", 32'(req_ready), 32'd1);
    chk("R12 no transfer", 32'(xfer_valid), 32'd0);
    chk("R12 no response", 32'(rsp_valid), 32'd0);
    chk("R12 drive bits", 32'(dev_sel), 32'd0);
    rst_n = 1;
    // R2: all bases 0 after reset, primary command wins
    access(0, 16'h0002, 2'd0, 32'h0);
    cfg(0, 16'h01F0); cfg(1, 16'h03F4); cfg(2, 16'h0170); cfg(3, 16'h0374); cfg(4, 16'hC000);
    cfg(0, 16'h0000);                                        // R4 zero ignored
    access(0, 16'h01F2, 2'd0, 32'h0);
    access(1, 16'h01F6, 2'd0, 32'h0000_0010);                // R6 R7 primary drive 1
    access(0, 16'h01F0, 2'd2, 32'h0);                        // R9 split read
    access(1, 16'h01F0, 2'd2, 32'h1234_ABCD);                // R9 split write
    access(0, 16'h0170, 2'd1, 32'h0);                        // R9 half
    access(0, 16'h01F0, 2'd0, 32'h0);                        // R10 byte on data port
    access(0, 16'h01F3, 2'd1, 32'h0);                        // R10 half on byte register
    access(0, 16'hC004, 2'd3, 32'h0);                        // R10 bad size code
    access(0, 16'h0100, 2'd0, 32'h0);                        // R11 miss
    access(0, 16'hC003, 2'd0, 32'h0);                        // R3 primary half
    access(0, 16'hC00A, 2'd2, 32'h0);                        // R3 secondary half
    slot_present = 4'b1101;
    access(0, 16'h01F2, 2'd0, 32'h0);                        // R8 empty read
    access(1, 16'h01F2, 2'd0, 32'hFF);                       // R8 empty write
    slot_present = 4'hF;
    io_en = 0;
    access(1, 16'h0176, 2'd0, 32'h10);                       // R5 select ignored
    access(0, 16'h0172, 2'd0, 32'h0);                        // R5 quiet read
    access(0, 16'h0200, 2'd0, 32'h0);                        // R11 miss while disabled
    io_en = 1;
    cfg(2, 16'h01F0);                                        // R2 overlap
    access(0, 16'h01F4, 2'd0, 32'h0);
    cfg(2, 16'h0170);
    for (int n = 0; n < 400; n++) begin
      int w; logic [15:0] a;
      w = $urandom % 6;
      if (w == 5) a = 16'($urandom);
      else a = m_base[w] + 16'($urandom % (win_size(w) + 4)) - 16'd2;
      io_en = ($urandom % 8) != 0;
      if ($urandom % 10 == 0) slot_present = 4'($urandom);
      access(1'($urandom), a, ($urandom % 5 == 0) ? 2'($urandom) : (((a - m_base[w]) == 0) ? 2'd2 : 2'd0),
             $urandom);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule